// File: doc/BRIEF.md
# UART Receive Buffer with Per-Entry Status

This block sits between the receive shift stage of a UART and the reader. Each time the shift stage finishes a frame it presents a data word, a ninth data bit and a framing-error flag for one cycle. The block stores these in a two-entry circular FIFO. The error flags and the ninth bit are kept with their data word. The reader sees the status of the head entry, then reads the data port, and that read removes the entry.

When both FIFO entries are occupied, a newly finished frame is not dropped. It waits in a hold register that models the shift register acting as a third buffer level, and a `hold_full` output tells the shift stage that it holds a frame. The held frame is lost only when the shift stage reports a new start bit, or delivers another frame, while the FIFO is still full. That loss sets an overrun flag, which is attached to the next entry written into the FIFO.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `rx_done`, `hold_full`, `rx_data`, `rx_bit9`, `rx_ferr` and `rx_ovr` are all 0.
- R2: A frame delivered while the FIFO has a free entry and nothing is held appears at the head on the cycle after `frm_valid`. `rx_done` is then high, and `rx_bit9` and `rx_ferr` equal the values delivered with that frame.
- R3: Entries leave the FIFO in arrival order. Each entry shows its own ninth bit and framing-error flag while it is at the head.
- R4: A `rd_pop` pulse while the FIFO holds entries removes the head entry on that clock edge. `rx_done` is low whenever the FIFO is empty, and the status outputs then read 0.
- R5: A frame delivered while both FIFO entries are full is kept in the hold register. `hold_full` goes high on the next cycle and the head entry does not change.
- R6: Once a FIFO entry is freed, the held frame moves into the FIFO on the following clock edge. `hold_full` then drops and the frame is later read in order, with its status.
- R7: A `start_det` pulse while a frame is held and the FIFO is full discards the held frame. The next entry written into the FIFO carries `rx_ovr` = 1, and entries written after it carry `rx_ovr` = 0.
- R8: A `rd_pop` while the FIFO is empty leaves `rx_data` at the last value read and does not move the pointers. The next frame is still read correctly.
- R9: A new frame delivered while a frame is held and the FIFO is full replaces the held frame. The replacing frame is the one later read, and it carries `rx_ovr` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle pulse: a frame is complete |
| frm_data | input | DW | Data bits of the completed frame |
| frm_bit9 | input | 1 | Ninth data bit of the completed frame |
| frm_ferr | input | 1 | Framing error of the completed frame |
| start_det | input | 1 | Shift stage saw a new start bit |
| rd_pop | input | 1 | Read strobe for the data port; pops the head entry |
| rx_data | output | DW | Head data, or the last value read when the FIFO is empty |
| rx_bit9 | output | 1 | Ninth bit of the head entry |
| rx_ferr | output | 1 | Framing error of the head entry |
| rx_ovr | output | 1 | Overrun flag of the head entry |
| rx_done | output | 1 | High while the FIFO holds at least one entry |
| hold_full | output | 1 | The shift register is holding a frame |

## Verification
A directly written frame, a pop, a loss from the hold register and a read of an empty port all show at the outputs one clock edge after the strobe. A held frame needs two edges after the pop that frees an entry: the first edge removes the head entry and the second moves the held frame into the FIFO. The bench drives every input on the falling edge and samples on the next falling edge. Where a result needs the second edge, the check waits one further falling edge before sampling, so every check lands in the cycle its result is due.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_bit9,
  input  logic          frm_ferr,
  input  logic          start_det,
  input  logic          rd_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_ferr,
  output logic          rx_ovr,
  output logic          rx_done,
  output logic          hold_full
);
  localparam int FW = DW + 2;
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [2];
  logic [FW-1:0] hold_q;
  logic [DW-1:0] last_q;
  logic [1:0]    cnt;
  logic          wptr, rptr, hold_v, ovr_pend;

  logic [FW-1:0] in_frm;
  logic          space, mv, dir, wr, pop, lose;
  logic [EW-1:0] head;

  assign in_frm = {frm_ferr, frm_bit9, frm_data};
  assign space  = (cnt != 2'd2);
  assign mv     = hold_v & space;
  assign dir    = frm_valid & ~hold_v & space;
  assign wr     = mv | dir;
  assign pop    = rd_pop & (cnt != 2'd0);
  assign lose   = hold_v & ~space & (frm_valid | start_det);
  assign head   = mem[rptr];

  assign rx_done   = (cnt != 2'd0);
  assign hold_full = hold_v;
  assign rx_data   = rx_done ? head[DW-1:0] : last_q;
  assign rx_bit9   = rx_done & head[DW];
  assign rx_ferr   = rx_done & head[DW+1];
  assign rx_ovr    = rx_done & head[DW+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0]   <= '0;
      mem[1]   <= '0;
      wptr     <= 1'b0;
      rptr     <= 1'b0;
      cnt      <= 2'd0;
      last_q   <= '0;
    end else begin
      if (wr) begin
        mem[wptr] <= {ovr_pend, mv ? hold_q : in_frm};
        wptr      <= ~wptr;
      end
      if (pop) begin
        last_q <= head[DW-1:0];
        rptr   <= ~rptr;
      end
      cnt <= cnt + {1'b0, wr} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v   <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (mv) begin
        hold_v <= frm_valid;
        if (frm_valid) hold_q <= in_frm;
      end else if (hold_v) begin
        if (frm_valid)      hold_q <= in_frm;
        else if (start_det) hold_v <= 1'b0;
      end else if (frm_valid && !space) begin
        hold_v <= 1'b1;
        hold_q <= in_frm;
      end
      if (lose)    ovr_pend <= 1'b1;
      else if (wr) ovr_pend <= 1'b0;
    end
  end
endmodule

module uart_rx_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_valid,
  input logic       start_det,
  input logic       rd_pop,
  input logic       hold_full,
  input logic       rx_done,
  input logic [1:0] cnt,
  input logic       wr,
  input logic       ovr_pend,
  input logic [7:0] rx_data
);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  a_r4_pop_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && cnt != 2'd0 && !wr) |=> (cnt == $past(cnt) - 2'd1));

  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && cnt == 2'd2 && !frm_valid && !start_det) |=> hold_full);

  a_r5_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2 && !rd_pop) |=> (rx_done && $stable(rx_data)));

  a_r7_drop_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && cnt == 2'd2 && start_det && !frm_valid) |=> (!hold_full && ovr_pend));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rx_done && !frm_valid && !hold_full) |=> (!rx_done && $stable(rx_data)));
endmodule

bind uart_rx_buffer uart_rx_buffer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .start_det(start_det),
  .rd_pop(rd_pop), .hold_full(hold_full), .rx_done(rx_done), .cnt(cnt),
  .wr(wr), .ovr_pend(ovr_pend), .rx_data(rx_data[7:0])
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0, frm_bit9 = 1'b0, frm_ferr = 1'b0;
  logic [7:0] frm_data = '0;
  logic       start_det = 1'b0, rd_pop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_ferr, rx_ovr, rx_done, hold_full;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  uart_rx_buffer #(.DW(8)) i_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_bit9(frm_bit9), .frm_ferr(frm_ferr), .start_det(start_det),
    .rd_pop(rd_pop), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ferr(rx_ferr),
    .rx_ovr(rx_ovr), .rx_done(rx_done), .hold_full(hold_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic head_is(input string req, input logic [7:0] d, input logic b9,
                         input logic fe, input logic ov);
    chk(req, {28'd0, rx_done, rx_ovr, rx_ferr, rx_bit9}, {28'd0, 1'b1, ov, fe, b9});
    chk(req, {24'd0, rx_data}, {24'd0, d});
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic fe);
    frm_valid = 1'b1; frm_data = d; frm_bit9 = b9; frm_ferr = fe;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", {26'd0, rx_done, hold_full, rx_bit9, rx_ferr, rx_ovr, 1'b0}, 32'd0);
    chk("R1", {24'd0, rx_data}, 32'd0);
  endtask

  task automatic t_single();
    send(8'hA5, 1'b1, 1'b0);
    head_is("R2", 8'hA5, 1'b1, 1'b0, 1'b0);
    pop();
    chk("R4", {31'd0, rx_done}, 32'd0);
    chk("R4", {29'd0, rx_bit9, rx_ferr, rx_ovr}, 32'd0);
    chk("R8", {24'd0, rx_data}, 32'hA5);
  endtask

  task automatic t_order();
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b0);
    head_is("R3", 8'h11, 1'b0, 1'b1, 1'b0);
    pop();
    head_is("R3", 8'h22, 1'b1, 1'b0, 1'b0);
    pop();
    chk("R4", {31'd0, rx_done}, 32'd0);
  endtask

  task automatic t_hold();
    send(8'h31, 1'b0, 1'b0);
    send(8'h32, 1'b0, 1'b0);
    send(8'h33, 1'b1, 1'b1);
    chk("R5", {31'd0, hold_full}, 32'd1);
    head_is("R5", 8'h31, 1'b0, 1'b0, 1'b0);
    pop();
    head_is("R6", 8'h32, 1'b0, 1'b0, 1'b0);
    chk("R6", {31'd0, hold_full}, 32'd1);
    idle();
    chk("R6", {31'd0, hold_full}, 32'd0);
    pop();
    head_is("R6", 8'h33, 1'b1, 1'b1, 1'b0);
    pop();
    chk("R6", {31'd0, rx_done}, 32'd0);
  endtask

  task automatic t_overrun();
    send(8'h41, 1'b0, 1'b0);
    send(8'h42, 1'b0, 1'b0);
    send(8'h43, 1'b0, 1'b0);
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
    chk("R7", {31'd0, hold_full}, 32'd0);
    head_is("R7", 8'h41, 1'b0, 1'b0, 1'b0);
    send(8'h44, 1'b1, 1'b0);
    chk("R7", {31'd0, hold_full}, 32'd1);
    pop();
    idle();
    head_is("R7", 8'h42, 1'b0, 1'b0, 1'b0);
    pop();
    head_is("R7", 8'h44, 1'b1, 1'b0, 1'b1);
    send(8'h45, 1'b0, 1'b0);
    pop();
    head_is("R7", 8'h45, 1'b0, 1'b0, 1'b0);
    pop();
  endtask

  task automatic t_replace();
    send(8'h51, 1'b0, 1'b0);
    send(8'h52, 1'b0, 1'b0);
    send(8'h53, 1'b0, 1'b0);
    send(8'h54, 1'b0, 1'b1);
    chk("R9", {31'd0, hold_full}, 32'd1);
    pop();
    idle();
    pop();
    head_is("R9", 8'h54, 1'b0, 1'b1, 1'b1);
    pop();
    chk("R9", {31'd0, rx_done}, 32'd0);
  endtask

  task automatic t_empty_read();
    pop();
    chk("R8", {31'd0, rx_done}, 32'd0);
    chk("R8", {24'd0, rx_data}, 32'h54);
    send(8'h61, 1'b1, 1'b0);
    head_is("R8", 8'h61, 1'b1, 1'b0, 1'b0);
    pop();
    chk("R8", {24'd0, rx_data}, 32'h61);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_hold();
    t_overrun();
    t_replace();
    t_empty_read();
    idle();
    finish_run();
  end
endmodule